// File: doc/BRIEF.md
# Interrupt Status, Enable and Mask Unit

This block gathers up to `WIDTH` single-cycle event pulses into a sticky status register and drives one interrupt line toward a processor. Two independent controls shape the result. A mask bit stops its source from ever reaching the status register. An enable bit lets a latched status bit drive the interrupt line, or stops it from doing so. Software clears a handled status bit by writing a one to it.

The enable register and the mask register each have two word addresses. One address sets bits and the other clears them, so software can change single bits without a read-modify-write. Both addresses of a pair read back the same register. The register bus is a plain single-cycle port with valid, write, address and data. Read data is registered and appears on the cycle after the read. The meaning of each source bit is defined by whatever is connected to it.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After synchronous reset, the status, enable and mask registers all read zero, and `irq_o` is low.
- R2: A source bit that is high while its mask bit is 0 sets its status bit at that clock edge. While the mask bit is 1, the source has no effect on status.
- R3: A write to word address 0 (status) clears every status bit written as 1 and leaves all other bits unchanged.
- R4: If a source pulse and a status clear hit the same bit in the same cycle, the bit ends up set.
- R5: A write to word address 1 ORs the write data into the enable register.
- R6: A write to word address 2 clears every enable bit written as 1.
- R7: A write to word address 3 ORs the data into the mask register. A write to word address 4 clears every mask bit written as 1.
- R8: A read (valid high, write low) returns the value the register held before that edge, on `rd_data_o` one cycle later. Address 0 returns status, addresses 1 and 2 return enable, and addresses 3 and 4 return mask.
- R9: `irq_o` is a register. After every clock edge it equals the OR of (status AND enable), using the values both registers take at that same edge.
- R10: Reads of word addresses 5 to 7 return zero, and writes to them change nothing. A bus cycle with valid low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | WIDTH | Event pulses, one per status bit |
| bus_valid_i | input | 1 | Register access this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | WIDTH | Write data |
| rd_data_o | output | WIDTH | Registered read data |
| irq_o | output | 1 | Interrupt line |

## Verification
The register updates and `irq_o` are due at the same rising edge that captures a write or a source pulse. Read data is due one edge after the read is presented. The bench drives every input on the falling edge and steps to the next rising edge. It checks `irq_o` and, after a read, `rd_data_o` on the following falling edge. The expected values come from a model that the bench advances with the same ordering: pre-edge values for read data and mask gating, post-edge values for status, enable and the interrupt line.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  // word addresses of the register map
  localparam int unsigned ADR_STATUS  = 0;
  localparam int unsigned ADR_EN_SET  = 1;
  localparam int unsigned ADR_EN_CLR  = 2;
  localparam int unsigned ADR_MSK_SET = 3;
  localparam int unsigned ADR_MSK_CLR = 4;

  typedef struct packed {
    logic stat_clr;
    logic en_set;
    logic en_clr;
    logic msk_set;
    logic msk_clr;
  } wr_strobe_t;
endpackage

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] d_o
);
  logic [WIDTH-1:0] set_bits, clr_bits;

  always_comb begin
    set_bits = set_we ? wdata : '0;
    clr_bits = clr_we ? wdata : '0;
    d_o      = (q_o | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_o;
  end

  // R5 / R7: set alias raises every written one
  a_r5_set_sticks: assert property (@(posedge clk) disable iff (rst)
    (set_we && !clr_we) |=> ((q_o & $past(wdata)) == $past(wdata)));
  // R6 / R7: clear alias drops every written one
  a_r6_clr_drops: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((q_o & $past(wdata)) == '0));
  // untouched register holds
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(q_o));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] src_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] d_o
);
  logic [WIDTH-1:0] evt, clr_bits;

  always_comb begin
    evt      = src_i & ~mask_i;
    clr_bits = clr_we ? wdata : '0;
    // event applied after clear: a same-cycle event wins
    d_o      = (q_o & ~clr_bits) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_o;
  end

  // R2 / R4: every unmasked event is latched
  a_r2_latch: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q_o & $past(src_i & ~mask_i)) == $past(src_i & ~mask_i)));
  // R2: newly set bits come only from unmasked events
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q_o & ~$past(q_o) & ~$past(src_i & ~mask_i)) == '0));
  // R3: cleared bits without a competing event are low
  a_r3_w1c: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((q_o & $past(wdata & ~(src_i & ~mask_i))) == '0));
endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port
  import irq_ctrl_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  status_i,
  input  logic [WIDTH-1:0]  enable_i,
  input  logic [WIDTH-1:0]  mask_i,
  output wr_strobe_t        we_o,
  output logic [WIDTH-1:0]  rd_data_o
);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(ADR_STATUS);
  localparam logic [ADDR_W-1:0] A_ES = ADDR_W'(ADR_EN_SET);
  localparam logic [ADDR_W-1:0] A_EC = ADDR_W'(ADR_EN_CLR);
  localparam logic [ADDR_W-1:0] A_MS = ADDR_W'(ADR_MSK_SET);
  localparam logic [ADDR_W-1:0] A_MC = ADDR_W'(ADR_MSK_CLR);

  logic             wr, rd;
  logic [WIDTH-1:0] rd_mux;

  always_comb begin
    wr = valid_i && write_i;
    rd = valid_i && !write_i;
    we_o.stat_clr = wr && (addr_i == A_ST);
    we_o.en_set   = wr && (addr_i == A_ES);
    we_o.en_clr   = wr && (addr_i == A_EC);
    we_o.msk_set  = wr && (addr_i == A_MS);
    we_o.msk_clr  = wr && (addr_i == A_MC);
    case (addr_i)
      A_ST:       rd_mux = status_i;
      A_ES, A_EC: rd_mux = enable_i;
      A_MS, A_MC: rd_mux = mask_i;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_data_o <= '0;
    else if (rd) rd_data_o <= rd_mux;
  end

  // R10: at most one register is targeted per access
  a_r10_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we_o));
  // R10: idle bus writes nothing
  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !valid_i |-> (we_o == '0));
  // R8: read data only moves after a read
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rd_data_o));
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
  import irq_ctrl_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  src_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WIDTH-1:0]  bus_wdata_i,
  output logic [WIDTH-1:0]  rd_data_o,
  output logic              irq_o
);
  wr_strobe_t       we;
  logic [WIDTH-1:0] st_q, st_d, en_q, en_d, mk_q, mk_d;

  irq_bus_port #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst),
    .valid_i(bus_valid_i), .write_i(bus_write_i), .addr_i(bus_addr_i),
    .status_i(st_q), .enable_i(en_q), .mask_i(mk_q),
    .we_o(we), .rd_data_o(rd_data_o)
  );

  irq_status_reg #(.WIDTH(WIDTH)) u_status (
    .clk(clk), .rst(rst), .src_i(src_i), .mask_i(mk_q),
    .clr_we(we.stat_clr), .wdata(bus_wdata_i), .q_o(st_q), .d_o(st_d)
  );

  irq_setclr_reg #(.WIDTH(WIDTH)) u_enable (
    .clk(clk), .rst(rst), .set_we(we.en_set), .clr_we(we.en_clr),
    .wdata(bus_wdata_i), .q_o(en_q), .d_o(en_d)
  );

  irq_setclr_reg #(.WIDTH(WIDTH)) u_mask (
    .clk(clk), .rst(rst), .set_we(we.msk_set), .clr_we(we.msk_clr),
    .wdata(bus_wdata_i), .q_o(mk_q), .d_o(mk_d)
  );

  // registered line, computed from next-state so it lands with the update
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(st_d & en_d);
  end

  // R9: line agrees with the registers after every edge
  a_r9_line: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(st_q & en_q)));
  // R1: reset lowers the line
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> !irq_o);
  // R2: mask register is unaffected by source activity
  a_r2_mask_indep: assert property (@(posedge clk) disable iff (rst)
    !bus_valid_i |=> (mk_q == $past(mk_q)));
endmodule

// File: tb/irq_ctrl_unit_test.sv
`timescale 1ns/1ps
module irq_ctrl_unit_test;
  localparam int W  = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [W-1:0]  src;
  logic          valid, wr;
  logic [AW-1:0] addr;
  logic [W-1:0]  wdata;
  logic [W-1:0]  rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] m_st, m_en, m_mk;

  always #2.5 clk = ~clk;

  irq_ctrl_unit #(.WIDTH(W), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .src_i(src), .bus_valid_i(valid), .bus_write_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .rd_data_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_read(input logic [AW-1:0] a);
    case (a)
      3'd0:       return m_st;
      3'd1, 3'd2: return m_en;
      3'd3, 3'd4: return m_mk;
      default:    return '0;
    endcase
  endfunction

  // one bus cycle; inputs driven at negedge, outputs checked at next negedge
  task automatic step(input logic v, input logic w, input logic [AW-1:0] a,
                      input logic [W-1:0] d, input logic [W-1:0] s, input string tag);
    logic [W-1:0] exp_rd, clr, old_mk;
    valid = v; wr = w; addr = a; wdata = d; src = s;
    exp_rd = model_read(a);
    old_mk = m_mk;
    clr    = '0;
    if (v && w) begin
      case (a)
        3'd0: clr  = d;
        3'd1: m_en = m_en | d;
        3'd2: m_en = m_en & ~d;
        3'd3: m_mk = m_mk | d;
        3'd4: m_mk = m_mk & ~d;
        default: ;
      endcase
    end
    m_st = (m_st & ~clr) | (s & ~old_mk);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R9 irq"}, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, |(m_st & m_en)});
    if (v && !w) chk({tag, " rdata"}, rdata, exp_rd);
    valid = 1'b0; src = '0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string tag);
    step(1'b1, 1'b0, a, '0, '0, tag);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; valid = 1'b0; wr = 1'b0; addr = '0; wdata = '0; src = '0;
    m_st = '0; m_en = '0; m_mk = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", {{(W-1){1'b0}}, irq}, '0);
    chk("R1 rdata after reset", rdata, '0);
    for (int i = 0; i < 5; i++) rd_chk(AW'(i), "R1 reset value");

    // R2: unmasked source latches; masked source ignored
    step(1'b0, 1'b0, '0, '0, 32'h0000_0008, "R2 latch");
    rd_chk(3'd0, "R2 status after event");
    step(1'b1, 1'b1, 3'd3, 32'h0000_0010, '0, "R7 mask set");
    rd_chk(3'd3, "R7 mask set readback");
    rd_chk(3'd4, "R8 mask clear-alias readback");
    step(1'b0, 1'b0, '0, '0, 32'h0000_0010, "R2 masked event");
    rd_chk(3'd0, "R2 masked source ignored");

    // R5 / R6 / R9: enable gates line
    step(1'b1, 1'b1, 3'd1, 32'h0000_0008, '0, "R5 enable set");
    chk("R9 irq high", {{(W-1){1'b0}}, irq}, 32'd1);
    rd_chk(3'd2, "R8 enable clear-alias readback");
    step(1'b1, 1'b1, 3'd2, 32'h0000_0008, '0, "R6 enable clear");
    chk("R6 irq low", {{(W-1){1'b0}}, irq}, '0);
    rd_chk(3'd1, "R6 enable readback");

    // R3: write-one-to-clear
    step(1'b0, 1'b0, '0, '0, 32'h0000_0003, "R2 two events");
    step(1'b1, 1'b1, 3'd0, 32'h0000_0009, '0, "R3 clear");
    rd_chk(3'd0, "R3 only written ones cleared");

    // R4: same-cycle event beats clear
    step(1'b1, 1'b1, 3'd0, 32'h0000_0001, 32'h0000_0001, "R4 collision");
    rd_chk(3'd0, "R4 event wins");

    // R7 mask clear then source latches again
    step(1'b1, 1'b1, 3'd4, 32'h0000_0010, '0, "R7 mask clear");
    step(1'b0, 1'b0, '0, '0, 32'h0000_0010, "R7 unmasked event");
    rd_chk(3'd0, "R7 source reaches status after unmask");

    // R10: unmapped address and idle bus
    step(1'b1, 1'b1, 3'd6, 32'hFFFF_FFFF, '0, "R10 unmapped write");
    rd_chk(3'd6, "R10 unmapped read zero");
    rd_chk(3'd1, "R10 enable untouched");
    step(1'b0, 1'b1, 3'd1, 32'hFFFF_FFFF, '0, "R10 idle write");
    rd_chk(3'd1, "R10 idle write ignored");
    rd_chk(3'd3, "R10 mask untouched");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [W-1:0] s, d;
      logic v, w;
      s = $urandom & $urandom & $urandom;
      d = $urandom & $urandom;
      v = ($urandom % 4) != 0;
      w = $urandom % 2;
      step(v, w, AW'($urandom % 8), d, s, "R8 random");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule